// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block brings an SDRAM subsystem out of power-up. It waits for the reset to be released and for an enable input to go active. It then asks a separate cycle engine to run four command cycles, one after another. For each cycle it presents a command code and holds a request line. It watches the engine's cycle-type vector to tell when each command has been served, and only then moves to the next one. When the last command has been served, it raises a setup-done flag that stays high until the next reset.

The block also supplies the 12-bit mode word that the engine places on the address pins during the load-mode cycle. The word is built at elaboration from parameters for burst length, burst ordering, read latency and write burst behaviour. All reserved fields of the word are zero. The enable input may change at any time relative to the clock, because it is synchronized inside the block. Tying it high starts the sequence as soon as reset has been released.

Top module: `sdr_init_seq`

## Requirements
- R1: While reset is asserted and just after it, `cmd_req` is 0, `setup_done` is 0 and `cmd_code` is 2'b00 (no operation).
- R2: While the enable input is low, no request is raised, however long the wait lasts.
- R3: After the enable input goes high, `cmd_req` stays low through two rising edges, counting the one that first samples the enable. It rises after the third edge.
- R4: The requested commands appear in this fixed order: 2'b01 (precharge), 2'b10 (auto-refresh) for NUM_AUTOREF cycles (two by default), then 2'b11 (load mode).
- R5: Each request, and its code, stays unchanged until the engine has shown cycle type 2'b01 (command) and has then returned to 2'b00 (idle). Cycle types 2'b10 (data) and 2'b11 (refresh) do not count as serving the request.
- R6: `setup_done` rises on the edge that samples idle after the load-mode command has been served. From then on `cmd_req` is 0 and `cmd_code` is 2'b00.
- R7: Once the sequence has started, taking the enable input low has no effect; the sequence still completes.
- R8: The mode word holds the burst length code in bits [2:0] (1→000, 2→001, 4→010, 8→011, full page→111), the burst ordering in bit 3 (1 = interleaved), the read latency in bits [6:4], and the single-write option in bit 9. Bits [8:7] and [11:10] are 0. With the default parameters (burst 4, sequential, latency 2, burst writes) the word is 12'h022.
- R9: With burst 8, interleaved ordering, latency 3 and single writes, the mode word is 12'h23B.
- R10: `setup_done` stays high, whatever the cycle-type input does, until reset. A new reset returns the block to the R1 state, and the block then waits for the enable input again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; asserts asynchronously, released synchronously inside the block |
| init_en_async | input | 1 | Initialization enable, may be asynchronous to clk |
| cyc_type | input | 2 | Cycle type from the engine: 00 idle, 01 command, 10 data, 11 refresh |
| cmd_code | output | 2 | Requested command: 00 none, 01 precharge, 10 auto-refresh, 11 load mode |
| cmd_req | output | 1 | Command-cycle request to the engine |
| mode_word | output | 12 | Mode register value for the load-mode cycle |
| setup_done | output | 1 | High once initialization has finished |

## Verification
On every cycle, the assertions check four things. The request and its code do not change while a step is still open. The done flag is sticky and keeps the request and code quiet. A request can only begin as precharge, right after the synchronized enable was high. The mode word's reserved fields stay zero. The bench scenarios show the rest. These are the exact latency from enable through the synchronizer, and the full command order against an engine model that delays its response and sends data and refresh cycle types before serving. They also cover indifference to the enable once running, the exact done edge, the mode word under two parameter sets, and the return to waiting after a second reset.

// File: rtl/sdr_init_pkg.sv
package sdr_init_pkg;

  typedef enum logic [1:0] {
    CMD_NOP  = 2'b00,
    CMD_PRE  = 2'b01,
    CMD_AREF = 2'b10,
    CMD_LMR  = 2'b11
  } init_cmd_e;

  typedef enum logic [1:0] {
    CYC_IDLE = 2'b00,
    CYC_CMD  = 2'b01,
    CYC_DATA = 2'b10,
    CYC_REF  = 2'b11
  } cyc_kind_e;

  typedef enum logic [2:0] {
    ST_WAIT = 3'd0,
    ST_PRE  = 3'd1,
    ST_AREF = 3'd2,
    ST_LMR  = 3'd3,
    ST_DONE = 3'd4
  } init_step_e;

  localparam int MODE_W = 12;

endpackage

// File: rtl/sdr_init_sync.sv
module sdr_init_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_async,
  output logic rst_n_int,
  output logic en_sync
);

  logic [STAGES-1:0] rst_pipe;
  logic [STAGES-1:0] en_pipe;

  // reset: asserted at once, released after STAGES clean edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[STAGES-2:0], 1'b1};
  end

  assign rst_n_int = rst_pipe[STAGES-1];

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) en_pipe <= '0;
    else            en_pipe <= {en_pipe[STAGES-2:0], en_async};
  end

  assign en_sync = en_pipe[STAGES-1];

endmodule

// File: rtl/sdr_init_mode.sv
module sdr_init_mode
  import sdr_init_pkg::*;
#(
  parameter int CAS_LAT       = 2,
  parameter int BURST_LEN     = 4,
  parameter bit BURST_ILEAVE  = 1'b0,
  parameter bit WRITE_SINGLE  = 1'b0
) (
  output logic [MODE_W-1:0] mode_word
);

  function automatic logic [2:0] bl_code(input int len);
    case (len)
      1:       bl_code = 3'b000;
      2:       bl_code = 3'b001;
      4:       bl_code = 3'b010;
      8:       bl_code = 3'b011;
      default: bl_code = 3'b111;
    endcase
  endfunction

  localparam logic [2:0] BL_F  = bl_code(BURST_LEN);
  localparam logic [2:0] CL_F  = 3'(CAS_LAT);

  assign mode_word = {2'b00, WRITE_SINGLE, 2'b00, CL_F, BURST_ILEAVE, BL_F};

endmodule

// File: rtl/sdr_init_fsm.sv
module sdr_init_fsm
  import sdr_init_pkg::*;
#(
  parameter int NUM_AUTOREF = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en_sync,
  input  logic [1:0] cyc_type,
  output logic [1:0] cmd_code,
  output logic       cmd_req,
  output logic       setup_done
);

  localparam int CNT_W = $clog2(NUM_AUTOREF + 1);

  init_step_e st, st_nxt;
  logic [CNT_W-1:0] aref_cnt, aref_cnt_nxt;
  logic served, served_nxt;
  logic step_end;

  assign step_end = served && (cyc_type == CYC_IDLE);

  always_comb begin
    st_nxt       = st;
    aref_cnt_nxt = aref_cnt;
    served_nxt   = served;
    case (st)
      ST_WAIT: begin
        served_nxt = 1'b0;
        if (en_sync) st_nxt = ST_PRE;
      end
      ST_PRE, ST_AREF, ST_LMR: begin
        if (cyc_type == CYC_CMD) served_nxt = 1'b1;
        if (step_end) begin
          served_nxt = 1'b0;
          case (st)
            ST_PRE: begin
              st_nxt       = ST_AREF;
              aref_cnt_nxt = CNT_W'(1);
            end
            ST_AREF: begin
              if (aref_cnt == CNT_W'(NUM_AUTOREF)) st_nxt = ST_LMR;
              else aref_cnt_nxt = aref_cnt + CNT_W'(1);
            end
            default: st_nxt = ST_DONE;
          endcase
        end
      end
      default: st_nxt = ST_DONE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_WAIT;
      aref_cnt <= '0;
      served   <= 1'b0;
    end else begin
      st       <= st_nxt;
      aref_cnt <= aref_cnt_nxt;
      served   <= served_nxt;
    end
  end

  always_comb begin
    case (st)
      ST_PRE:  cmd_code = CMD_PRE;
      ST_AREF: cmd_code = CMD_AREF;
      ST_LMR:  cmd_code = CMD_LMR;
      default: cmd_code = CMD_NOP;
    endcase
  end

  assign cmd_req    = (st == ST_PRE) || (st == ST_AREF) || (st == ST_LMR);
  assign setup_done = (st == ST_DONE);

  // R5
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_req && !step_end) |=> (cmd_req && $stable(cmd_code)));

  // R6
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    setup_done |=> setup_done);

  // R6
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    setup_done |-> (!cmd_req && cmd_code == CMD_NOP));

endmodule

// File: rtl/sdr_init_seq.sv
module sdr_init_seq
  import sdr_init_pkg::*;
#(
  parameter int NUM_AUTOREF  = 2,
  parameter int SYNC_STAGES  = 2,
  parameter int CAS_LAT      = 2,
  parameter int BURST_LEN    = 4,
  parameter bit BURST_ILEAVE = 1'b0,
  parameter bit WRITE_SINGLE = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init_en_async,
  input  logic [1:0]        cyc_type,
  output logic [1:0]        cmd_code,
  output logic              cmd_req,
  output logic [MODE_W-1:0] mode_word,
  output logic              setup_done
);

  logic rst_n_int;
  logic en_sync;

  sdr_init_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_async  (init_en_async),
    .rst_n_int (rst_n_int),
    .en_sync   (en_sync)
  );

  sdr_init_fsm #(.NUM_AUTOREF(NUM_AUTOREF)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .en_sync    (en_sync),
    .cyc_type   (cyc_type),
    .cmd_code   (cmd_code),
    .cmd_req    (cmd_req),
    .setup_done (setup_done)
  );

  sdr_init_mode #(
    .CAS_LAT      (CAS_LAT),
    .BURST_LEN    (BURST_LEN),
    .BURST_ILEAVE (BURST_ILEAVE),
    .WRITE_SINGLE (WRITE_SINGLE)
  ) u_mode (
    .mode_word (mode_word)
  );

  // R2
  start_on_en_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    $rose(cmd_req) |-> $past(en_sync));

  // R4
  start_pre_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    $rose(cmd_req) |-> (cmd_code == CMD_PRE));

  // R8
  mode_rsvd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_word[11:10] == 2'b00) && (mode_word[8:7] == 2'b00));

endmodule

// File: tb/sdr_init_seq_tb.sv
module sdr_init_seq_tb;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic [1:0] cyc = 2'b00;
  logic [1:0] code;
  logic req;
  logic [11:0] mword;
  logic done;
  logic [1:0] code2;
  logic req2;
  logic [11:0] mword2;
  logic done2;

  int checks = 0;
  int errors = 0;
  int n_served = 0;
  bit engine_on = 1'b0;
  logic [1:0] exp_q[$];

  always #4 clk = ~clk;

  sdr_init_seq u_dut (
    .clk(clk), .rst_n(rst_n), .init_en_async(en), .cyc_type(cyc),
    .cmd_code(code), .cmd_req(req), .mode_word(mword), .setup_done(done)
  );

  sdr_init_seq #(.CAS_LAT(3), .BURST_LEN(8), .BURST_ILEAVE(1'b1), .WRITE_SINGLE(1'b1)) u_dut2 (
    .clk(clk), .rst_n(rst_n), .init_en_async(1'b0), .cyc_type(2'b00),
    .cmd_code(code2), .cmd_req(req2), .mode_word(mword2), .setup_done(done2)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic push_seq();
    exp_q.push_back(2'b01);
    exp_q.push_back(2'b10);
    exp_q.push_back(2'b10);
    exp_q.push_back(2'b11);
  endtask

  // monitor: engine model, pops expected codes as commands are served
  initial begin
    logic [1:0] seen;
    logic [1:0] want;
    forever begin
      @(negedge clk);
      if (engine_on && req) begin
        seen = code;
        repeat (3) begin
          @(negedge clk);
          check(req && code == seen, "R5 hold while idle", code, seen);
        end
        if (n_served == 0) begin
          cyc = 2'b11;
          repeat (2) begin
            @(negedge clk);
            check(req && code == seen, "R5 refresh type ignored", code, seen);
          end
          cyc = 2'b10;
          @(negedge clk);
          check(req && code == seen, "R5 data type ignored", code, seen);
          cyc = 2'b00;
          @(negedge clk);
          check(req && code == seen, "R5 no advance without command", code, seen);
        end
        cyc = 2'b01;
        @(negedge clk);
        @(negedge clk);
        check(req && code == seen && !done, "R5 held during command", code, seen);
        cyc = 2'b00;
        want = (exp_q.size() > 0) ? exp_q.pop_front() : 2'bxx;
        check(seen === want, "R4 command order", seen, want);
        n_served++;
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", n_served, 4);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!req && code == 2'b00 && !done, "R1 in reset", {req, code, done}, 0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    check(!req && code == 2'b00 && !done, "R1 after reset", {req, code, done}, 0);
    check(mword == 12'h022, "R8 default mode word", mword, 12'h022);
    check(mword2 == 12'h23B, "R9 variant mode word", mword2, 12'h23B);
    repeat (10) @(negedge clk);
    check(!req, "R2 no request with enable low", req, 0);

    push_seq();
    engine_on = 1'b1;
    en = 1'b1;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    check(!req, "R3 not yet after two edges", req, 0);
    @(posedge clk);
    @(negedge clk);
    check(req && code == 2'b01, "R3 request after third edge", {req, code}, 3'b101);

    while (n_served < 1) @(negedge clk);
    en = 1'b0;
    while (n_served < 4) @(negedge clk);
    check(!done, "R6 not done before idle sampled", done, 0);
    @(negedge clk);
    check(done, "R7 finished with enable low", done, 1);
    check(done && !req && code == 2'b00, "R6 done and quiet", {done, req, code}, 3'b100);
    check(exp_q.size() == 0, "R4 all commands served", exp_q.size(), 0);
    engine_on = 1'b0;

    cyc = 2'b01;
    repeat (3) @(negedge clk);
    cyc = 2'b11;
    repeat (3) @(negedge clk);
    cyc = 2'b00;
    repeat (2) @(negedge clk);
    check(done && !req && code == 2'b00, "R10 done sticky", {done, req, code}, 3'b100);

    rst_n = 1'b0;
    #1;
    check(!done && !req && code == 2'b00, "R10 reset clears", {done, req, code}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (12) @(negedge clk);
    check(!req && !done, "R2 waits for enable after reset", {req, done}, 0);
    en = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(req && code == 2'b01, "R10 restarts with precharge", {req, code}, 3'b101);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule